// File: doc/BRIEF.md
# Tree-label distance routing unit

This unit makes the next-hop decision for one router of an on-chip network whose usable links form an irregular graph over a spanning tree. Every node owns a hierarchical label of sixteen 2-bit digits: the root is all zeros, and each level down the tree sets one more digit, from the most significant digit toward the least. The hop count between two nodes along the tree can then be computed from their labels alone. No routing table is needed.

The unit holds the router's own label and the labels of its four neighbours (E, N, S, W), together with a flag per neighbour that says whether the link is usable. These are loaded during initialisation. A packet header carries up to five destination labels. For every destination, five distance calculators run in parallel: one from the local node and one from each neighbour. The unit then picks an output port. The tree route is the default. A non-tree shortcut is taken only when the neighbour across it is strictly closer to the destination and the link is not busy. The per-destination choices and the OR of their one-hot port bits are registered one cycle after the header is presented.

Top module: `tl_route_unit`

## Requirements
- R1: A label is 32 bits, digit k in bits 2k+1:2k, with digit 15 the most significant. Depth is the number of non-zero digits counted from digit 15 down to the first zero digit. Tree distance is depth(a) + depth(b) - 2 x (number of leading digits that are equal and non-zero in both).
- R2: When cfg_we_i is high at a clock edge, select 0 writes the local label. Selects 1 to 4 write the label of E, N, S or W, and cfg_link_ok_i becomes that neighbour's usable flag. After reset the local label is zero and every neighbour is unusable.
- R3: A valid destination equal to the local label selects port code 4 (L).
- R4: The tree port is the first usable neighbour, in the order E, N, S, W, that is at distance 1 from the local node and one hop closer to the destination than the local node. When no neighbour is strictly closer than it, the tree port is selected. Port codes are E=0, N=1, S=2, W=3.
- R5: A usable, non-busy neighbour whose distance to the destination is strictly smaller than the best so far replaces the choice, so the nearest such neighbour wins.
- R6: On equal distance the earlier candidate is kept, in the order tree port, E, N, S, W.
- R7: A neighbour whose usable flag is clear is never selected.
- R8: A busy neighbour (nbr_busy_i bit set, bit 0 = E to bit 3 = W) is not taken as a shortcut, but a busy tree port is still selected.
- R9: With no tree port, the nearest usable non-busy neighbour is chosen (ties E, N, S, W). If there is none, the slot reports code 7 (no route) and contributes no mask bit.
- R10: res_mask_o bit p (E=0, N=1, S=2, W=3, L=4) is set when any valid destination slot chose port p. A slot whose hdr_dest_vld_i bit is clear reports code 7.
- R11: res_valid_o equals hdr_valid_i of the previous cycle. Port codes and mask update only on a cycle with hdr_valid_i high and hold otherwise. Reset gives res_valid_o 0, mask 0 and every port code 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Label write strobe |
| cfg_sel_i | input | 3 | Write target: 0 local, 1 E, 2 N, 3 S, 4 W |
| cfg_label_i | input | 32 | Label value to store |
| cfg_link_ok_i | input | 1 | Usable flag for the addressed neighbour |
| hdr_valid_i | input | 1 | Header present this cycle |
| hdr_dest_i | input | 160 | Five destination labels, slot 0 in bits 31:0 |
| hdr_dest_vld_i | input | 5 | Per-slot destination valid |
| nbr_busy_i | input | 4 | Per-neighbour busy (E, N, S, W) |
| res_valid_o | output | 1 | Result valid |
| res_port_o | output | 15 | Five 3-bit port codes, slot 0 in bits 2:0 |
| res_mask_o | output | 5 | Combined output-port mask |

## Verification
The assertions assume well-formed labels, meaning no non-zero digit below a zero digit. They also assume the stored neighbours agree with a single spanning tree, so that at most one neighbour qualifies as the tree port. They further assume nbr_busy_i and the stored labels describe the same cycle in which the header is sampled. The stimulus builds one consistent five-node neighbourhood (parent, child and two shortcuts around a depth-2 node). It changes only usable flags and busy bits, and it never writes configuration in the same cycle as a header, so every destination label it sends is a legal tree position.

// File: rtl/tl_route_pkg.sv
package tl_route_pkg;
  localparam int NUM_NBR   = 4;
  localparam int NUM_PORTS = NUM_NBR + 1;
  localparam int PORT_W    = 3;
  localparam int SEL_W     = 3;

  localparam logic [PORT_W-1:0] PORT_E    = 3'd0;
  localparam logic [PORT_W-1:0] PORT_N    = 3'd1;
  localparam logic [PORT_W-1:0] PORT_S    = 3'd2;
  localparam logic [PORT_W-1:0] PORT_W_   = 3'd3;
  localparam logic [PORT_W-1:0] PORT_L    = 3'd4;
  localparam logic [PORT_W-1:0] PORT_NONE = 3'd7;
endpackage

// File: rtl/tl_dist_calc.sv
module tl_dist_calc #(
  parameter int DIGIT_W    = 2,
  parameter int NUM_DIGITS = 16,
  parameter int LABEL_W    = DIGIT_W * NUM_DIGITS,
  parameter int DEPTH_W    = $clog2(NUM_DIGITS + 1),
  parameter int DIST_W     = DEPTH_W + 1
) (
  input  logic [LABEL_W-1:0] a_i,
  input  logic [LABEL_W-1:0] b_i,
  output logic [DIST_W-1:0]  dist_o
);
  logic               run_a, run_b, run_c;
  logic [DEPTH_W-1:0] depth_a, depth_b, common;
  logic [DIGIT_W-1:0] dig_a, dig_b;

  // R1: walk digits from the top; each run stops at the first break
  always_comb begin
    run_a   = 1'b1;
    run_b   = 1'b1;
    run_c   = 1'b1;
    depth_a = '0;
    depth_b = '0;
    common  = '0;
    dig_a   = '0;
    dig_b   = '0;
    for (int i = NUM_DIGITS - 1; i >= 0; i--) begin
      dig_a = a_i[i*DIGIT_W +: DIGIT_W];
      dig_b = b_i[i*DIGIT_W +: DIGIT_W];
      run_a = run_a && (dig_a != '0);
      run_b = run_b && (dig_b != '0);
      run_c = run_c && (dig_a == dig_b) && (dig_a != '0);
      if (run_a) depth_a = depth_a + DEPTH_W'(1);
      if (run_b) depth_b = depth_b + DEPTH_W'(1);
      if (run_c) common  = common + DEPTH_W'(1);
    end
    dist_o = DIST_W'(depth_a) + DIST_W'(depth_b) - (DIST_W'(common) << 1);
  end
endmodule

// File: rtl/tl_label_store.sv
module tl_label_store
  import tl_route_pkg::*;
#(
  parameter int LABEL_W = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cfg_we_i,
  input  logic [SEL_W-1:0]                cfg_sel_i,
  input  logic [LABEL_W-1:0]              cfg_label_i,
  input  logic                            cfg_link_ok_i,
  output logic [LABEL_W-1:0]              local_o,
  output logic [NUM_NBR-1:0][LABEL_W-1:0] nbr_label_o,
  output logic [NUM_NBR-1:0]              nbr_ok_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               local_o <= '0;
    else if (cfg_we_i && cfg_sel_i == '0)      local_o <= cfg_label_i;
  end

  for (genvar g = 0; g < NUM_NBR; g++) begin : g_nbr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        nbr_label_o[g] <= '0;
        nbr_ok_o[g]    <= 1'b0;
      end else if (cfg_we_i && cfg_sel_i == SEL_W'(g + 1)) begin
        nbr_label_o[g] <= cfg_label_i;
        nbr_ok_o[g]    <= cfg_link_ok_i;
      end
    end
  end

  p_cfg_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i == SEL_W'(1)) |=>
      (nbr_label_o[0] == $past(cfg_label_i) && nbr_ok_o[0] == $past(cfg_link_ok_i)));
endmodule

// File: rtl/tl_port_select.sv
module tl_port_select
  import tl_route_pkg::*;
#(
  parameter int DIGIT_W    = 2,
  parameter int NUM_DIGITS = 16,
  parameter int LABEL_W    = DIGIT_W * NUM_DIGITS,
  parameter int DEPTH_W    = $clog2(NUM_DIGITS + 1),
  parameter int DIST_W     = DEPTH_W + 1
) (
  input  logic [LABEL_W-1:0]              local_i,
  input  logic [NUM_NBR-1:0][LABEL_W-1:0] nbr_label_i,
  input  logic [NUM_NBR-1:0]              nbr_ok_i,
  input  logic [NUM_NBR-1:0]              nbr_adj_i,
  input  logic [NUM_NBR-1:0]              nbr_busy_i,
  input  logic [LABEL_W-1:0]              dest_i,
  input  logic                            dest_vld_i,
  output logic [PORT_W-1:0]               port_o
);
  logic [DIST_W-1:0]              d_loc;
  logic [NUM_NBR-1:0][DIST_W-1:0] d_nbr;

  tl_dist_calc #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS), .LABEL_W(LABEL_W),
                 .DEPTH_W(DEPTH_W), .DIST_W(DIST_W))
    u_loc (.a_i(local_i), .b_i(dest_i), .dist_o(d_loc));

  for (genvar g = 0; g < NUM_NBR; g++) begin : g_calc
    tl_dist_calc #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS), .LABEL_W(LABEL_W),
                   .DEPTH_W(DEPTH_W), .DIST_W(DIST_W))
      u_nbr (.a_i(nbr_label_i[g]), .b_i(dest_i), .dist_o(d_nbr[g]));
  end

  logic              tree_hit;
  logic [PORT_W-1:0] tree_port, best;
  logic [DIST_W-1:0] tree_d, best_d;

  // R4: tree port is a tree-adjacent neighbour one hop nearer the destination
  always_comb begin
    tree_hit  = 1'b0;
    tree_port = PORT_NONE;
    tree_d    = '1;
    for (int i = 0; i < NUM_NBR; i++) begin
      if (!tree_hit && nbr_ok_i[i] && nbr_adj_i[i] &&
          (DIST_W'(d_nbr[i] + DIST_W'(1)) == d_loc)) begin
        tree_hit  = 1'b1;
        tree_port = PORT_W'(i);
        tree_d    = d_nbr[i];
      end
    end
  end

  // R5/R6/R8: strictly closer, non-busy shortcut overrides; earlier kept on tie
  always_comb begin
    best   = tree_port;
    best_d = tree_d;
    for (int i = 0; i < NUM_NBR; i++) begin
      if (nbr_ok_i[i] && !nbr_busy_i[i] && d_nbr[i] < best_d) begin
        best   = PORT_W'(i);
        best_d = d_nbr[i];
      end
    end
  end

  always_comb begin
    if (!dest_vld_i)             port_o = PORT_NONE;
    else if (dest_i == local_i)  port_o = PORT_L;
    else                         port_o = best;
  end
endmodule

// File: rtl/tl_route_unit.sv
module tl_route_unit
  import tl_route_pkg::*;
#(
  parameter int NUM_DEST = 5,
  parameter int DIGIT_W  = 2,
  parameter int LABEL_W  = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_we_i,
  input  logic [SEL_W-1:0]             cfg_sel_i,
  input  logic [LABEL_W-1:0]           cfg_label_i,
  input  logic                         cfg_link_ok_i,
  input  logic                         hdr_valid_i,
  input  logic [NUM_DEST*LABEL_W-1:0]  hdr_dest_i,
  input  logic [NUM_DEST-1:0]          hdr_dest_vld_i,
  input  logic [NUM_NBR-1:0]           nbr_busy_i,
  output logic                         res_valid_o,
  output logic [NUM_DEST*PORT_W-1:0]   res_port_o,
  output logic [NUM_PORTS-1:0]         res_mask_o
);
  localparam int NUM_DIGITS = LABEL_W / DIGIT_W;
  localparam int DEPTH_W    = $clog2(NUM_DIGITS + 1);
  localparam int DIST_W     = DEPTH_W + 1;

  logic [LABEL_W-1:0]              local_lbl;
  logic [NUM_NBR-1:0][LABEL_W-1:0] nbr_lbl;
  logic [NUM_NBR-1:0]              nbr_ok;
  logic [NUM_NBR-1:0]              nbr_adj;

  tl_label_store #(.LABEL_W(LABEL_W)) u_store (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_label_i, .cfg_link_ok_i,
    .local_o(local_lbl), .nbr_label_o(nbr_lbl), .nbr_ok_o(nbr_ok)
  );

  // tree adjacency: neighbour exactly one tree hop from the local node
  for (genvar g = 0; g < NUM_NBR; g++) begin : g_adj
    logic [DIST_W-1:0] d_adj;
    tl_dist_calc #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS), .LABEL_W(LABEL_W),
                   .DEPTH_W(DEPTH_W), .DIST_W(DIST_W))
      u_adj (.a_i(local_lbl), .b_i(nbr_lbl[g]), .dist_o(d_adj));
    assign nbr_adj[g] = (d_adj == DIST_W'(1));
  end

  logic [NUM_DEST-1:0][PORT_W-1:0] sel_port;

  for (genvar k = 0; k < NUM_DEST; k++) begin : g_dest
    tl_port_select #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS), .LABEL_W(LABEL_W),
                     .DEPTH_W(DEPTH_W), .DIST_W(DIST_W)) u_sel (
      .local_i    (local_lbl),
      .nbr_label_i(nbr_lbl),
      .nbr_ok_i   (nbr_ok),
      .nbr_adj_i  (nbr_adj),
      .nbr_busy_i (nbr_busy_i),
      .dest_i     (hdr_dest_i[k*LABEL_W +: LABEL_W]),
      .dest_vld_i (hdr_dest_vld_i[k]),
      .port_o     (sel_port[k])
    );
  end

  logic [NUM_PORTS-1:0] mask_d;
  always_comb begin
    mask_d = '0;
    for (int k = 0; k < NUM_DEST; k++) begin
      if (sel_port[k] < PORT_W'(NUM_PORTS)) mask_d[sel_port[k]] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_port_o  <= {NUM_DEST{PORT_NONE}};
      res_mask_o  <= '0;
    end else begin
      res_valid_o <= hdr_valid_i;
      if (hdr_valid_i) begin
        res_port_o <= sel_port;
        res_mask_o <= mask_d;
      end
    end
  end

  p_valid_follows_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i |=> res_valid_o);
  p_valid_drops_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdr_valid_i |=> (!res_valid_o && $stable(res_mask_o) && $stable(res_port_o)));
  p_local_to_l_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && hdr_dest_vld_i[0] && hdr_dest_i[LABEL_W-1:0] == local_lbl) |=>
      res_port_o[PORT_W-1:0] == PORT_L);
  p_empty_slot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && !hdr_dest_vld_i[0]) |=> res_port_o[PORT_W-1:0] == PORT_NONE);
  p_slot_in_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i |=> (res_port_o[PORT_W-1:0] == PORT_NONE ||
                     res_mask_o[res_port_o[PORT_W-1:0]]));
  p_no_dead_link_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i |=> ((res_mask_o[NUM_NBR-1:0] & ~$past(nbr_ok)) == '0));
  p_busy_shortcut_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i |=> ((res_mask_o[NUM_NBR-1:0] & $past(nbr_busy_i & ~nbr_adj)) == '0));
endmodule

// File: tb/tb_tl_route_unit.sv
module tb_tl_route_unit;
  import tl_route_pkg::*;

  localparam int ND = 5;
  localparam int LW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [2:0]      cfg_sel = '0;
  logic [LW-1:0]   cfg_label = '0;
  logic            cfg_ok = 1'b0;
  logic            hdr_valid = 1'b0;
  logic [ND*LW-1:0] hdr_dest = '0;
  logic [ND-1:0]   hdr_vld = '0;
  logic [3:0]      busy = '0;
  logic            res_valid;
  logic [ND*3-1:0] res_port;
  logic [4:0]      res_mask;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  tl_route_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_label_i(cfg_label), .cfg_link_ok_i(cfg_ok), .hdr_valid_i(hdr_valid),
    .hdr_dest_i(hdr_dest), .hdr_dest_vld_i(hdr_vld), .nbr_busy_i(busy),
    .res_valid_o(res_valid), .res_port_o(res_port), .res_mask_o(res_mask)
  );

  // local 1-2-0, E parent 1-0-0, N child 1-2-1, S shortcut 2-0-0, W shortcut 1-1-0
  localparam logic [LW-1:0] LOC = 32'h6000_0000;
  localparam logic [LW-1:0] L_E = 32'h4000_0000;
  localparam logic [LW-1:0] L_N = 32'h6400_0000;
  localparam logic [LW-1:0] L_S = 32'h8000_0000;
  localparam logic [LW-1:0] L_W = 32'h5000_0000;

  // {destination, expected port}
  localparam int NV = 9;
  localparam logic [34:0] VEC [NV] = '{
    {32'hA000_0000, 3'd2},  // R5 shortcut S strictly closer
    {32'h6700_0000, 3'd1},  // R4 down the tree via N
    {32'h5800_0000, 3'd3},  // R5 shortcut W
    {32'h4000_0000, 3'd0},  // R4 destination is the parent
    {32'h0000_0000, 3'd0},  // R6 tree ties with S
    {32'h6000_0000, 3'd4},  // R3 local
    {32'h8000_0000, 3'd2},  // R5 destination is S itself
    {32'h5000_0000, 3'd3},  // R5 destination is W itself
    {32'hC000_0000, 3'd0}   // R6 tree ties with S
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [LW-1:0] lbl, input logic ok);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_label = lbl; cfg_ok = ok;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [ND*LW-1:0] d, input logic [ND-1:0] v, input logic [3:0] b);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_dest = d; hdr_vld = v; busy = b;
    @(negedge clk);
    hdr_valid = 1'b0; busy = '0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset valid", {31'd0, res_valid}, 32'd0);
    chk("R11 reset mask", {27'd0, res_mask}, 32'd0);
    chk("R11 reset ports", {17'd0, res_port}, {17'd0, {5{3'd7}}});
    rst_n = 1'b1;

    // R2 reset state: local zero, neighbours unusable; R3 / R9
    send({96'd0, L_E, 32'd0}, 5'b00011, 4'b0);
    chk("R11 valid after header", {31'd0, res_valid}, 32'd1);
    chk("R3 R2 reset local is root", {29'd0, res_port[2:0]}, 32'd4);
    chk("R9 R2 no usable neighbour", {29'd0, res_port[5:3]}, 32'd7);
    chk("R10 mask reset topology", {27'd0, res_mask}, 32'b10000);

    cfg(3'd0, LOC, 1'b0);
    cfg(3'd1, L_E, 1'b1);
    cfg(3'd2, L_N, 1'b1);
    cfg(3'd3, L_S, 1'b1);
    cfg(3'd4, L_W, 1'b1);

    for (int i = 0; i < NV; i++) begin
      send({128'd0, VEC[i][34:3]}, 5'b00001, 4'b0);
      chk($sformatf("R1 R4 R5 R6 vector %0d port", i), {29'd0, res_port[2:0]}, {29'd0, VEC[i][2:0]});
      chk($sformatf("R10 vector %0d mask", i), {27'd0, res_mask}, 32'(5'd1 << VEC[i][2:0]));
    end

    // R10 multi-destination
    send({L_E, LOC, 32'h5800_0000, 32'h6700_0000, 32'hA000_0000}, 5'b11111, 4'b0);
    chk("R10 five ports", {17'd0, res_port}, {17'd0, 3'd0, 3'd4, 3'd3, 3'd1, 3'd2});
    chk("R10 five mask", {27'd0, res_mask}, 32'b11111);
    send({L_E, LOC, 32'h5800_0000, 32'h6700_0000, 32'hA000_0000}, 5'b10101, 4'b0);
    chk("R10 sparse ports", {17'd0, res_port}, {17'd0, 3'd0, 3'd7, 3'd3, 3'd7, 3'd2});
    chk("R10 sparse mask", {27'd0, res_mask}, 32'b01101);

    // R11 hold while idle
    repeat (2) @(negedge clk);
    chk("R11 valid low when idle", {31'd0, res_valid}, 32'd0);
    chk("R11 mask held", {27'd0, res_mask}, 32'b01101);
    chk("R11 ports held", {17'd0, res_port}, {17'd0, 3'd0, 3'd7, 3'd3, 3'd7, 3'd2});

    // R8 busy shortcut skipped, busy tree port kept
    send({128'd0, 32'hA000_0000}, 5'b00001, 4'b0100);
    chk("R8 busy shortcut S", {29'd0, res_port[2:0]}, 32'd0);
    send({128'd0, 32'h0000_0000}, 5'b00001, 4'b0001);
    chk("R8 busy tree port E", {29'd0, res_port[2:0]}, 32'd0);

    // R7 unusable link
    cfg(3'd3, L_S, 1'b0);
    send({128'd0, 32'hA000_0000}, 5'b00001, 4'b0);
    chk("R7 dead S not used", {29'd0, res_port[2:0]}, 32'd0);
    send({128'd0, L_S}, 5'b00001, 4'b0);
    chk("R7 dead S as destination", {29'd0, res_port[2:0]}, 32'd0);

    // R9 no tree port: nearest usable wins, then none at all
    cfg(3'd1, L_E, 1'b0);
    send({128'd0, 32'h0000_0000}, 5'b00001, 4'b0);
    chk("R9 fallback nearest W", {29'd0, res_port[2:0]}, 32'd3);
    cfg(3'd2, L_N, 1'b0);
    cfg(3'd4, L_W, 1'b0);
    send({128'd0, 32'h0000_0000}, 5'b00001, 4'b0);
    chk("R9 no route code", {29'd0, res_port[2:0]}, 32'd7);
    chk("R9 no route mask", {27'd0, res_mask}, 32'd0);

    done = 1'b1;
    summary();
  end
endmodule